// File: doc/BRIEF.md
# Nonvolatile Write Controller with Data Polling

This block sits on the memory side of an in-system programming path. It holds a word-wide flash array and a byte-wide EEPROM array in registers. It takes single-cycle commands from a command decoder: load a word into a page buffer, commit the buffer to a flash page, write one EEPROM byte, read either array, or erase both arrays.

A flash commit writes every word of the selected page in one step. An EEPROM write replaces the whole addressed byte, as if the cell were erased first and then written. Each write starts a busy interval whose length in clock cycles is set by a parameter. The block has no separate ready flag. Instead, a read of a location that is still being programmed returns all ones. For flash this applies to any word of the page being written. For EEPROM it applies only to the byte being written. Software can poll a written location until the programmed value reads back.

A command that modifies storage and arrives during a busy interval is dropped, because it could corrupt the write in progress. Such a command also sets a sticky error flag.

Top module: `nvm_commit_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, `rd_valid` and `busy_err` are 0. Every flash word reads all ones, and every EEPROM byte reads 0x00FF.
- R2: `cmd_op` encodings are: 0 none, 1 load page buffer, 2 flash commit, 3 EEPROM write, 4 flash read, 5 EEPROM read, 6 chip erase, 7 reserved. A read accepted at a clock edge makes `rd_valid` 1 and updates `rd_data` at the next edge. EEPROM data is zero-extended. Any other command, including code 7, leaves `rd_valid` at 0 and changes no storage.
- R3: A load stores `cmd_wdata` in page-buffer slot `cmd_addr[2:0]`. A commit copies all eight buffer slots at once into the flash page `cmd_addr[5:3]`.
- R4: After a commit sampled at edge E0, flash reads sampled at edges E1 through E1+FLASH_BUSY-1 return 0xFFFF for any word of the committed page. From the next edge on, they return the programmed words.
- R5: During a flash busy interval, reads of words outside the committed page, and EEPROM reads, return the stored values.
- R6: An EEPROM write replaces the byte at `cmd_addr[4:0]` with `cmd_wdata[7:0]`, with no merging of old bits. For EE_BUSY edges after the write, reads of that byte return 0x00FF. Reads of other bytes are unaffected.
- R7: A command of type 1, 2, 3 or 6 sampled during a busy interval is dropped and changes no storage. It also sets `busy_err`, which stays 1 until reset.
- R8: Chip erase, when not busy, sets every flash word and every EEPROM byte to all ones. The next command sees the erased values.
- R9: Reads sampled during a busy interval are served and never set `busy_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_addr | input | ADDR_W | Word, page or byte address |
| cmd_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | DATA_W | Read result, all ones while the location is busy |
| busy_err | output | 1 | Sticky flag for a dropped write-type command |

## Verification
The bench keeps the default array shape: 64 flash words in pages of 8, and 32 EEPROM bytes. It shortens the busy times to 6 cycles for flash and 4 for EEPROM. With these values, a single test can step through the whole polling window, one command per cycle, and hit both the last busy edge and the first ready edge. A write can also be dropped mid-window, and the bench then confirms that the untouched page buffer and EEPROM byte still hold their earlier values.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
   typedef enum logic [2:0] {
      OP_NONE   = 3'd0,
      OP_LOAD   = 3'd1,
      OP_COMMIT = 3'd2,
      OP_EE_WR  = 3'd3,
      OP_FL_RD  = 3'd4,
      OP_EE_RD  = 3'd5,
      OP_ERASE  = 3'd6,
      OP_RSVD   = 3'd7
   } nvm_op_e;

   typedef enum logic [1:0] {
      WR_IDLE  = 2'd0,
      WR_FLASH = 2'd1,
      WR_EE    = 2'd2
   } wr_kind_e;

   function automatic logic op_is_write(input logic [2:0] op);
      return (op == OP_LOAD) || (op == OP_COMMIT) || (op == OP_EE_WR) || (op == OP_ERASE);
   endfunction

   function automatic logic op_is_read(input logic [2:0] op);
      return (op == OP_FL_RD) || (op == OP_EE_RD);
   endfunction
endpackage

// File: rtl/nvm_busy_timer.sv
module nvm_busy_timer
   import nvm_pkg::*;
#(
   parameter int FLASH_BUSY = 40,
   parameter int EE_BUSY    = 24,
   parameter int ADDR_W     = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_flash,
   input  logic              start_ee,
   input  logic [ADDR_W-1:0] start_addr,
   output logic              busy,
   output wr_kind_e          kind,
   output logic [ADDR_W-1:0] held_addr
);
   localparam int MAX_BUSY = (FLASH_BUSY > EE_BUSY) ? FLASH_BUSY : EE_BUSY;
   localparam int CNT_W    = $clog2(MAX_BUSY + 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         kind      <= WR_IDLE;
         held_addr <= '0;
      end else if (start_flash) begin
         cnt_q     <= CNT_W'(FLASH_BUSY);
         kind      <= WR_FLASH;
         held_addr <= start_addr;
      end else if (start_ee) begin
         cnt_q     <= CNT_W'(EE_BUSY);
         kind      <= WR_EE;
         held_addr <= start_addr;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
         if (cnt_q == CNT_W'(1)) kind <= WR_IDLE;
      end
   end

   assign busy = (cnt_q != '0);
endmodule

// File: rtl/nvm_flash_store.sv
module nvm_flash_store #(
   parameter int WORDS      = 64,
   parameter int PAGE_WORDS = 8,
   parameter int DATA_W     = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load_en,
   input  logic                      commit_en,
   input  logic                      erase_en,
   input  logic [$clog2(WORDS)-1:0]  addr,
   input  logic [DATA_W-1:0]         wdata,
   output logic [DATA_W-1:0]         rd_word
);
   localparam int FAW   = $clog2(WORDS);
   localparam int OFS_W = $clog2(PAGE_WORDS);
   localparam int PG_W  = FAW - OFS_W;

   logic [PAGE_WORDS-1:0][DATA_W-1:0] buf_q;
   logic [WORDS-1:0][DATA_W-1:0]      mem_q, mem_d;
   logic [PG_W-1:0]                   tgt_page;

   assign tgt_page = addr[FAW-1:OFS_W];

   always_ff @(posedge clk) begin
      if (!rst_n)       buf_q <= '1;
      else if (load_en) buf_q[addr[OFS_W-1:0]] <= wdata;
   end

   for (genvar g = 0; g < WORDS; g++) begin : g_word
      localparam logic [PG_W-1:0] MY_PAGE = PG_W'(g / PAGE_WORDS);
      assign mem_d[g] = erase_en                          ? '1 :
                        (commit_en && tgt_page == MY_PAGE) ? buf_q[g % PAGE_WORDS] :
                                                             mem_q[g];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) mem_q <= '1;
      else        mem_q <= mem_d;
   end

   assign rd_word = mem_q[addr];
endmodule

// File: rtl/nvm_ee_store.sv
module nvm_ee_store #(
   parameter int BYTES = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic                      erase_en,
   input  logic [$clog2(BYTES)-1:0]  addr,
   input  logic [7:0]                wdata,
   output logic [7:0]                rd_byte
);
   localparam int EAW = $clog2(BYTES);

   logic [BYTES-1:0][7:0] mem_q, mem_d;

   for (genvar g = 0; g < BYTES; g++) begin : g_byte
      assign mem_d[g] = erase_en                            ? 8'hFF :
                        (wr_en && addr == EAW'(g))          ? wdata :
                                                              mem_q[g];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) mem_q <= '1;
      else        mem_q <= mem_d;
   end

   assign rd_byte = mem_q[addr];
endmodule

// File: rtl/nvm_commit_ctrl.sv
module nvm_commit_ctrl
   import nvm_pkg::*;
#(
   parameter int FLASH_WORDS = 64,
   parameter int PAGE_WORDS  = 8,
   parameter int DATA_W      = 16,
   parameter int EE_BYTES    = 32,
   parameter int ADDR_W      = 6,
   parameter int FLASH_BUSY  = 40,
   parameter int EE_BUSY     = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy_err
);
   localparam int FAW   = $clog2(FLASH_WORDS);
   localparam int EAW   = $clog2(EE_BYTES);
   localparam int OFS_W = $clog2(PAGE_WORDS);

   if ((PAGE_WORDS & (PAGE_WORDS - 1)) != 0 || PAGE_WORDS < 2) begin : g_bad_page
      $error("PAGE_WORDS must be a power of two of at least 2");
   end
   if ((FLASH_WORDS & (FLASH_WORDS - 1)) != 0 || FLASH_WORDS < 2 * PAGE_WORDS) begin : g_bad_flash
      $error("FLASH_WORDS must be a power of two holding at least two pages");
   end
   if ((EE_BYTES & (EE_BYTES - 1)) != 0 || EE_BYTES < 2) begin : g_bad_ee
      $error("EE_BYTES must be a power of two of at least 2");
   end
   if (ADDR_W < FAW || ADDR_W < EAW) begin : g_bad_addr
      $error("ADDR_W too narrow for the arrays");
   end
   if (FLASH_BUSY < 1 || EE_BUSY < 1 || DATA_W < 8) begin : g_bad_misc
      $error("busy times must be at least 1 and DATA_W at least 8");
   end

   logic              wr_req, accept, busy;
   logic              flash_hit, ee_hit;
   wr_kind_e          kind;
   logic [ADDR_W-1:0] held_addr;
   logic [DATA_W-1:0] fl_word;
   logic [7:0]        ee_byte;

   assign wr_req = cmd_valid && op_is_write(cmd_op);
   assign accept = wr_req && !busy;

   nvm_busy_timer #(
      .FLASH_BUSY (FLASH_BUSY),
      .EE_BUSY    (EE_BUSY),
      .ADDR_W     (ADDR_W)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_flash (accept && cmd_op == OP_COMMIT),
      .start_ee    (accept && cmd_op == OP_EE_WR),
      .start_addr  (cmd_addr),
      .busy        (busy),
      .kind        (kind),
      .held_addr   (held_addr)
   );

   nvm_flash_store #(
      .WORDS      (FLASH_WORDS),
      .PAGE_WORDS (PAGE_WORDS),
      .DATA_W     (DATA_W)
   ) u_flash (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (accept && cmd_op == OP_LOAD),
      .commit_en (accept && cmd_op == OP_COMMIT),
      .erase_en  (accept && cmd_op == OP_ERASE),
      .addr      (cmd_addr[FAW-1:0]),
      .wdata     (cmd_wdata),
      .rd_word   (fl_word)
   );

   nvm_ee_store #(
      .BYTES (EE_BYTES)
   ) u_ee (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (accept && cmd_op == OP_EE_WR),
      .erase_en (accept && cmd_op == OP_ERASE),
      .addr     (cmd_addr[EAW-1:0]),
      .wdata    (cmd_wdata[7:0]),
      .rd_byte  (ee_byte)
   );

   assign flash_hit = busy && kind == WR_FLASH &&
                      cmd_addr[FAW-1:OFS_W] == held_addr[FAW-1:OFS_W];
   assign ee_hit    = busy && kind == WR_EE &&
                      cmd_addr[EAW-1:0] == held_addr[EAW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
         busy_err <= 1'b0;
      end else begin
         rd_valid <= cmd_valid && op_is_read(cmd_op);
         if (cmd_valid && cmd_op == OP_FL_RD)
            rd_data <= flash_hit ? '1 : fl_word;
         else if (cmd_valid && cmd_op == OP_EE_RD)
            rd_data <= ee_hit ? DATA_W'(8'hFF) : DATA_W'(ee_byte);
         if (wr_req && busy) busy_err <= 1'b1;
      end
   end
endmodule

// File: rtl/nvm_commit_ctrl_chk.sv
module nvm_commit_ctrl_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [2:0]        cmd_op,
   input logic              rd_valid,
   input logic [DATA_W-1:0] rd_data,
   input logic              busy_err,
   input logic              busy,
   input logic              flash_hit,
   input logic              ee_hit
);
   logic is_rd, is_wr;
   assign is_rd = cmd_valid && (cmd_op == 3'd4 || cmd_op == 3'd5);
   assign is_wr = cmd_valid && (cmd_op == 3'd1 || cmd_op == 3'd2 ||
                                cmd_op == 3'd3 || cmd_op == 3'd6);

   AST_RD_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      is_rd |=> rd_valid); // R2
   AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !is_rd |=> !rd_valid); // R2
   AST_FLASH_POLL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd4 && flash_hit) |=> rd_data == '1); // R4
   AST_EE_POLL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd5 && ee_hit) |=> rd_data == DATA_W'(8'hFF)); // R6
   AST_DROP_FLAGS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wr && busy) |=> busy_err); // R7
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      busy_err |=> busy_err); // R7
   AST_READ_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && !busy_err) |=> !busy_err); // R9
endmodule

bind nvm_commit_ctrl nvm_commit_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .rd_valid  (rd_valid),
   .rd_data   (rd_data),
   .busy_err  (busy_err),
   .busy      (busy),
   .flash_hit (flash_hit),
   .ee_hit    (ee_hit)
);

// File: tb/nvm_commit_ctrl_test.sv
`timescale 1ns/1ps
module nvm_commit_ctrl_test;
   localparam int FB = 6;
   localparam int EB = 4;
   localparam int VW = 3 + 6 + 16 + 1 + 16;
   localparam int NV = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = 3'd0;
   logic [5:0]  cmd_addr = '0;
   logic [15:0] cmd_wdata = '0;
   logic        rd_valid, busy_err;
   logic [15:0] rd_data;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   nvm_commit_ctrl #(.FLASH_BUSY(FB), .EE_BUSY(EB)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rd_valid(rd_valid),
      .rd_data(rd_data), .busy_err(busy_err));

   // {op, addr, wdata, check, expected rd_data}; op 0 = idle cycle
   localparam logic [VW-1:0] VECS [NV] = '{
      {3'd3, 6'd4, 16'h0033, 1'b0, 16'h0000},
      {3'd0, 6'd0, 16'h0000, 1'b0, 16'h0000},
      {3'd0, 6'd0, 16'h0000, 1'b0, 16'h0000},
      {3'd0, 6'd0, 16'h0000, 1'b0, 16'h0000},
      {3'd0, 6'd0, 16'h0000, 1'b0, 16'h0000},
      {3'd3, 6'd3, 16'h005A, 1'b0, 16'h0000},
      {3'd5, 6'd3, 16'h0000, 1'b1, 16'h00FF},
      {3'd5, 6'd4, 16'h0000, 1'b1, 16'h0033},
      {3'd0, 6'd0, 16'h0000, 1'b0, 16'h0000},
      {3'd5, 6'd3, 16'h0000, 1'b1, 16'h00FF},
      {3'd5, 6'd3, 16'h0000, 1'b1, 16'h005A},
      {3'd3, 6'd3, 16'h00A5, 1'b0, 16'h0000},
      {3'd0, 6'd0, 16'h0000, 1'b0, 16'h0000},
      {3'd0, 6'd0, 16'h0000, 1'b0, 16'h0000},
      {3'd0, 6'd0, 16'h0000, 1'b0, 16'h0000},
      {3'd0, 6'd0, 16'h0000, 1'b0, 16'h0000},
      {3'd5, 6'd3, 16'h0000, 1'b1, 16'h00A5},
      {3'd4, 6'd9, 16'h0000, 1'b1, 16'hFFFF},
      {3'd7, 6'd3, 16'h0000, 1'b0, 16'h0000},
      {3'd5, 6'd3, 16'h0000, 1'b1, 16'h00A5}
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   // drive at a falling edge, sampled at the next rising edge; returns at the following falling edge
   task automatic issue(input logic [2:0] op, input logic [5:0] a, input logic [15:0] d);
      cmd_valid = (op != 3'd0);
      cmd_op    = op;
      cmd_addr  = a;
      cmd_wdata = d;
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_op    = 3'd0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) issue(3'd0, 6'd0, 16'h0);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 rd_valid in reset", {15'd0, rd_valid}, 16'd0);
      check("R1 busy_err in reset", {15'd0, busy_err}, 16'd0);
      rst_n = 1'b1;
      @(negedge clk);
      issue(3'd4, 6'd40, 16'h0);
      check("R1 erased flash", rd_data, 16'hFFFF);
      issue(3'd5, 6'd17, 16'h0);
      check("R1 erased eeprom", rd_data, 16'h00FF);

      for (int i = 0; i < NV; i++) begin
         logic [VW-1:0] v;
         v = VECS[i];
         issue(v[41:39], v[38:33], v[32:17]);
         if (v[16]) begin
            check((v[41:39] == 3'd5) ? "R6 table eeprom" : "R2 table read", rd_data, v[15:0]);
            check("R2 table rd_valid", {15'd0, rd_valid}, 16'd1);
         end else begin
            check("R2 table no rd_valid", {15'd0, rd_valid}, 16'd0);
         end
      end
      check("R2 reserved op no error", {15'd0, busy_err}, 16'd0);

      // page 0 program and read back
      for (int i = 0; i < 8; i++) issue(3'd1, 6'(i), 16'h00A0 + 16'(i));
      issue(3'd2, 6'd0, 16'h0);
      idle(FB);
      issue(3'd4, 6'd3, 16'h0);
      check("R3 page0 word3", rd_data, 16'h00A3);
      issue(3'd4, 6'd7, 16'h0);
      check("R3 page0 word7", rd_data, 16'h00A7);

      // page 2 program with polling window
      for (int i = 0; i < 8; i++) issue(3'd1, 6'(16 + i), 16'h1000 + 16'(i));
      issue(3'd2, 6'd16, 16'h0);                          // E0
      issue(3'd4, 6'd19, 16'h0);                          // E1
      check("R4 busy page read", rd_data, 16'hFFFF);
      issue(3'd4, 6'd5, 16'h0);                           // E2
      check("R5 outside page read", rd_data, 16'h00A5);
      check("R9 reads keep error clear", {15'd0, busy_err}, 16'd0);
      issue(3'd1, 6'd16, 16'hDEAD);                       // E3 dropped
      check("R7 drop raises error", {15'd0, busy_err}, 16'd1);
      issue(3'd5, 6'd4, 16'h0);                           // E4
      check("R5 eeprom during flash busy", rd_data, 16'h0033);
      idle(1);                                            // E5
      issue(3'd4, 6'd23, 16'h0);                          // E6 last busy
      check("R4 last busy edge", rd_data, 16'hFFFF);
      issue(3'd4, 6'd23, 16'h0);                          // E7 ready
      check("R4 first ready edge", rd_data, 16'h1007);

      // recommit page 2 with the retained buffer; drop an eeprom write
      issue(3'd2, 6'd16, 16'h0);
      issue(3'd3, 6'd4, 16'h0077);
      idle(FB - 1);
      issue(3'd4, 6'd16, 16'h0);
      check("R7 dropped load left buffer", rd_data, 16'h1000);
      issue(3'd5, 6'd4, 16'h0);
      check("R7 dropped eeprom write", rd_data, 16'h0033);
      check("R7 error sticky", {15'd0, busy_err}, 16'd1);

      issue(3'd6, 6'd0, 16'h0);
      issue(3'd4, 6'd16, 16'h0);
      check("R8 erase flash page2", rd_data, 16'hFFFF);
      issue(3'd5, 6'd3, 16'h0);
      check("R8 erase eeprom", rd_data, 16'h00FF);
      issue(3'd4, 6'd0, 16'h0);
      check("R8 erase flash page0", rd_data, 16'hFFFF);

      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 error cleared by reset", {15'd0, busy_err}, 16'd0);

      done = 1'b1;
      finish_run();
   end
endmodule